// File: doc/BRIEF.md
# Dual-Window Peak Stabilizer

This block keeps one reference peak of a pulse-height spectrum at a fixed channel. It watches a stream of channel numbers, one per accepted event. Around a programmed centroid it places two counting windows of equal width, one on the low side and one on the high side, with a programmable gap of channels between them. Events that land in either window are counted. When one of the two counts reaches the programmed rate divider, the block compares the high/low count ratio with a programmed target. It then moves a signed correction word one step toward balance, within a programmed limit, and starts a new batch of counts. The correction word drives an external gain or offset actuator. One instance can track a gain reference near the top of the spectrum, and a second instance can track a zero reference near the bottom.

A small state machine does the sequencing. Its states are ST_OFF (stabilizer disabled, correction zero), ST_ACC (counting events), ST_ADJ (one cycle that compares, steps and clears the counters) and ST_HOLD (correction and counts frozen). Mode Off moves any state to ST_OFF. From ST_OFF, mode On leads to ST_ACC and mode Hold leads to ST_HOLD. ST_ACC moves to ST_ADJ when a count has reached the threshold and no clear is requested, and moves to ST_HOLD on mode Hold. ST_ADJ always leaves after one cycle, to ST_HOLD on mode Hold and to ST_ACC otherwise. ST_HOLD returns to ST_ACC on mode On.

Top module: `peak_stab`

## Requirements
- R1: After reset the correction output is 0, both window counts are empty and the state machine is in ST_OFF.
- R2: With half-gap h = floor(gap/2), an event is a low-window hit when centroid-h-width <= chan < centroid-h. It is a high-window hit when centroid-h+gap <= chan < centroid-h+gap+width. The two windows never overlap.
- R3: An event in neither window changes no count and no correction.
- R4: A correction step happens only once the low count or the high count has reached the threshold. The threshold is rate_div, and a rate_div of 0 acts as 1. The step appears on corr_out two clock edges after the edge that counted the deciding event, and both counts are cleared in the same cycle. An event presented in the adjust cycle is not counted.
- R5: ratio is unsigned fixed point with FRAC fraction bits (256 = 1.0 by default). If high*2^FRAC > low*ratio, the correction decreases by 1. If it is smaller, the correction increases by 1. If the two are equal, the correction does not change.
- R6: A step never takes the correction outside the range -corr_limit to +corr_limit; at a bound the step saturates.
- R7: mode encoding: 0 = Off, 1 = On, 2 and 3 = Hold. In Off, corr_out goes to 0 on the next edge, the counts are cleared and events are ignored.
- R8: In Hold, corr_out keeps its value and events are not counted. The counts already held are kept until On resumes.
- R9: A pulse on clr_cnt empties both counts and leaves corr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | An event channel is presented this cycle |
| evt_chan | input | CH_W | Channel number of the event |
| clr_cnt | input | 1 | Empty both window counts |
| mode | input | 2 | 0 Off, 1 On, 2/3 Hold |
| centroid | input | CH_W | Reference peak position in channels |
| win_width | input | CH_W | Width of each window in channels |
| win_gap | input | CH_W | Channels between the two windows |
| ratio | input | RAT_W | Target high/low count ratio, FRAC fraction bits |
| rate_div | input | CNT_W | Count threshold per correction step |
| corr_limit | input | COR_W-1 | Magnitude bound for the correction |
| corr_out | output | COR_W | Signed correction value |

## Verification
The assertions take for granted that the settings (centroid, width, gap, ratio, rate divider and limit) stay constant while a count batch is open. They also take for granted that the limit never drops below the present correction magnitude. The stimulus changes settings only right after a step has emptied the counts, and it never lowers the limit under the present correction. Events are spaced far enough apart that none lands in the adjust cycle, so the reference model can count every event that is sent.

// File: rtl/stab_pkg.sv
package stab_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ACC  = 2'd1,
        ST_ADJ  = 2'd2,
        ST_HOLD = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

endpackage

// File: rtl/stab_window.sv
module stab_window #(
    parameter int CH_W = 13
) (
    input  logic [CH_W-1:0] chan,
    input  logic [CH_W-1:0] centroid,
    input  logic [CH_W-1:0] width,
    input  logic [CH_W-1:0] gap,
    output logic            hit_lo,
    output logic            hit_up
);
    localparam int SW = CH_W + 3;

    logic signed [SW-1:0] ch_s, lo_end, lo_beg, up_beg, up_end;

    // Window edges in a signed, widened domain so none of them wraps.
    always_comb begin
        ch_s   = $signed({3'b000, chan});
        lo_end = $signed({3'b000, centroid}) - $signed({4'b0000, gap[CH_W-1:1]});
        lo_beg = lo_end - $signed({3'b000, width});
        up_beg = lo_end + $signed({3'b000, gap});
        up_end = up_beg + $signed({3'b000, width});
        hit_lo = (ch_s >= lo_beg) && (ch_s < lo_end);
        hit_up = (ch_s >= up_beg) && (ch_s < up_end);
    end

endmodule

// File: rtl/stab_ratio_cmp.sv
module stab_ratio_cmp
    import stab_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RAT_W = 12,
    parameter int FRAC  = 8
) (
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] up_cnt,
    input  logic [RAT_W-1:0] ratio,
    output dir_e             dir
);
    localparam int PW = CNT_W + RAT_W + FRAC;

    logic [PW-1:0] lhs, rhs;

    // Cross-multiplied ratio test: high * 2^FRAC against low * ratio.
    always_comb begin
        lhs = PW'(up_cnt) << FRAC;
        rhs = PW'(lo_cnt) * PW'(ratio);
        if (lhs > rhs)      dir = DIR_DOWN;
        else if (lhs < rhs) dir = DIR_UP;
        else                dir = DIR_NONE;
    end

endmodule

// File: rtl/peak_stab.sv
module peak_stab
    import stab_pkg::*;
#(
    parameter int CH_W  = 13,
    parameter int CNT_W = 16,
    parameter int RAT_W = 12,
    parameter int FRAC  = 8,
    parameter int COR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_valid,
    input  logic [CH_W-1:0]         evt_chan,
    input  logic                    clr_cnt,
    input  logic [1:0]              mode,
    input  logic [CH_W-1:0]         centroid,
    input  logic [CH_W-1:0]         win_width,
    input  logic [CH_W-1:0]         win_gap,
    input  logic [RAT_W-1:0]        ratio,
    input  logic [CNT_W-1:0]        rate_div,
    input  logic [COR_W-2:0]        corr_limit,
    output logic signed [COR_W-1:0] corr_out
);
    localparam int EW = COR_W + 1;

    st_e                     state, nxt;
    logic [CNT_W-1:0]        lo_cnt, up_cnt, thr;
    logic signed [COR_W-1:0] corr_q;
    logic                    hit_lo, hit_up, reached;
    logic                    m_off, m_run, m_hold;
    dir_e                    dir;
    logic signed [EW-1:0]    sum_s, step_s, lim_s, nlim_s, clamp_s;

    stab_window #(.CH_W(CH_W)) u_win (
        .chan     (evt_chan),
        .centroid (centroid),
        .width    (win_width),
        .gap      (win_gap),
        .hit_lo   (hit_lo),
        .hit_up   (hit_up)
    );

    stab_ratio_cmp #(.CNT_W(CNT_W), .RAT_W(RAT_W), .FRAC(FRAC)) u_cmp (
        .lo_cnt (lo_cnt),
        .up_cnt (up_cnt),
        .ratio  (ratio),
        .dir    (dir)
    );

    assign m_off   = (mode == 2'd0);
    assign m_run   = (mode == 2'd1);
    assign m_hold  = mode[1];
    assign thr     = (rate_div == '0) ? CNT_W'(1) : rate_div;
    assign reached = (lo_cnt >= thr) || (up_cnt >= thr);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (m_off) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = m_run ? ST_ACC : ST_HOLD;
                ST_ACC:  nxt = m_hold ? ST_HOLD : ((reached && !clr_cnt) ? ST_ADJ : ST_ACC);
                ST_ADJ:  nxt = m_hold ? ST_HOLD : ST_ACC;
                ST_HOLD: nxt = m_run ? ST_ACC : ST_HOLD;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // One step toward balance, clamped to the limit
    always_comb begin
        unique case (dir)
            DIR_UP:   step_s = EW'(1);
            DIR_DOWN: step_s = -EW'(1);
            default:  step_s = '0;
        endcase
        sum_s  = $signed({corr_q[COR_W-1], corr_q}) + step_s;
        lim_s  = $signed({2'b00, corr_limit});
        nlim_s = -lim_s;
        if (sum_s > lim_s)       clamp_s = lim_s;
        else if (sum_s < nlim_s) clamp_s = nlim_s;
        else                     clamp_s = sum_s;
    end

    // Output process: correction word and window counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_q <= '0;
            lo_cnt <= '0;
            up_cnt <= '0;
        end else if (m_off) begin
            corr_q <= '0;
            lo_cnt <= '0;
            up_cnt <= '0;
        end else if (state == ST_ADJ) begin
            corr_q <= clamp_s[COR_W-1:0];
            lo_cnt <= '0;
            up_cnt <= '0;
        end else if (clr_cnt) begin
            lo_cnt <= '0;
            up_cnt <= '0;
        end else if (state == ST_ACC && evt_valid) begin
            if (hit_lo && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
            if (hit_up && up_cnt != '1) up_cnt <= up_cnt + 1'b1;
        end
    end

    assign corr_out = corr_q;

    // ---------------- assertions ----------------
    a_r2_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_lo && hit_up));

    a_r4_counts_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADJ) |=> (lo_cnt == '0 && up_cnt == '0));

    a_r4_quiet_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && !m_off) |=> $stable(corr_q));

    a_r6_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADJ) |=>
            ($signed({corr_q[COR_W-1], corr_q}) <= $signed({2'b00, $past(corr_limit)}) &&
             $signed({corr_q[COR_W-1], corr_q}) >= -$signed({2'b00, $past(corr_limit)})));

    a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (corr_q == '0));

    a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> $stable(corr_q));

endmodule

// File: tb/sim_peak_stab.sv
module sim_peak_stab;
    localparam int CH_W = 13, CNT_W = 16, RAT_W = 12, FRAC = 8, COR_W = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    evt_valid = 1'b0;
    logic [CH_W-1:0]         evt_chan = '0;
    logic                    clr_cnt = 1'b0;
    logic [1:0]              mode = 2'd0;
    logic [CH_W-1:0]         centroid = '0;
    logic [CH_W-1:0]         win_width = '0;
    logic [CH_W-1:0]         win_gap = '0;
    logic [RAT_W-1:0]        ratio = '0;
    logic [CNT_W-1:0]        rate_div = '0;
    logic [COR_W-2:0]        corr_limit = '0;
    logic signed [COR_W-1:0] corr_out;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    // reference model state
    int m_corr = 0, m_lo = 0, m_up = 0;

    always #10 clk = ~clk;   // 50 MHz

    peak_stab #(.CH_W(CH_W), .CNT_W(CNT_W), .RAT_W(RAT_W), .FRAC(FRAC), .COR_W(COR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_chan(evt_chan),
        .clr_cnt(clr_cnt), .mode(mode), .centroid(centroid), .win_width(win_width),
        .win_gap(win_gap), .ratio(ratio), .rate_div(rate_div), .corr_limit(corr_limit),
        .corr_out(corr_out)
    );

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (int'(corr_out) != e) begin
                    n_bad++;
                    $display("FAIL %s: corr_out=%0d expected %0d", t, int'(corr_out), e);
                end
            end
        end
    end

    task automatic expect_corr(input string t);
        exp_q.push_back(m_corr);
        tag_q.push_back(t);
    endtask

    // model of the stepping rule (R2, R3, R4, R5, R6)
    task automatic model_event(input int ch);
        int h, lo_end, lo_beg, up_beg, up_end, thr, lhs, rhs, nx;
        if (mode != 2'd1) return;
        h = int'(win_gap) / 2;
        lo_end = int'(centroid) - h;
        lo_beg = lo_end - int'(win_width);
        up_beg = lo_end + int'(win_gap);
        up_end = up_beg + int'(win_width);
        if (ch >= lo_beg && ch < lo_end) m_lo++;
        if (ch >= up_beg && ch < up_end) m_up++;
        thr = (rate_div == 0) ? 1 : int'(rate_div);
        if (m_lo >= thr || m_up >= thr) begin
            lhs = m_up * (1 << FRAC);
            rhs = m_lo * int'(ratio);
            nx = m_corr;
            if (lhs > rhs) nx = m_corr - 1;
            else if (lhs < rhs) nx = m_corr + 1;
            if (nx > int'(corr_limit)) nx = int'(corr_limit);
            if (nx < -int'(corr_limit)) nx = -int'(corr_limit);
            m_corr = nx;
            m_lo = 0;
            m_up = 0;
        end
    endtask

    task automatic send(input int ch, input string t);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_chan  = CH_W'(ch);
        @(negedge clk);
        evt_valid = 1'b0;
        model_event(ch);
        repeat (4) @(negedge clk);
        expect_corr(t);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        if (m == 2'd0) begin
            m_corr = 0; m_lo = 0; m_up = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
        m_lo = 0; m_up = 0;
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_corr("R1 reset value");

        centroid = 13'd1000; win_width = 13'd20; win_gap = 13'd10;
        ratio = 12'd256; rate_div = 16'd1; corr_limit = 11'd100;
        set_mode(2'd1);

        // R2: window edges (low 975..994, high 1005..1024); R3: outside ignored
        send(975,  "R2 low edge 975");
        send(994,  "R2 low edge 994");
        send(995,  "R3 gap 995");
        send(1004, "R3 gap 1004");
        send(974,  "R3 below 974");
        send(1025, "R3 above 1025");
        send(1005, "R2 high edge 1005");
        send(1024, "R2 high edge 1024");

        // R4: rate_div 0 acts as 1, then threshold 4
        rate_div = 16'd0;
        send(980, "R4 rate_div zero");
        rate_div = 16'd4;
        for (int i = 0; i < 3; i++) send(1010, "R4 below threshold");
        send(985,  "R4 below threshold");
        send(1010, "R4 threshold reached");

        // R5: target ratio 2.0
        ratio = 12'd512;
        send(985, "R5 batch equal");
        send(985, "R5 batch equal");
        for (int i = 0; i < 4; i++) send(1010, "R5 equal no step");
        send(985, "R5 high heavy");
        for (int i = 0; i < 4; i++) send(1010, "R5 high heavy step down");
        send(1010, "R5 low heavy");
        for (int i = 0; i < 4; i++) send(985, "R5 low heavy step up");

        // R9: clear empties counts, keeps correction
        ratio = 12'd256;
        for (int i = 0; i < 3; i++) send(1010, "R9 before clear");
        pulse_clear();
        expect_corr("R9 corr kept");
        @(negedge clk);
        send(1010, "R9 after clear");
        send(1010, "R9 after clear");
        for (int i = 0; i < 4; i++) send(985, "R9 step from cleared counts");

        // R6: saturation at +/-2
        rate_div = 16'd1; corr_limit = 11'd2;
        for (int i = 0; i < 3; i++) send(985, "R6 upper bound");
        for (int i = 0; i < 5; i++) send(1010, "R6 lower bound");

        // R8: hold freezes (mode 2 and 3)
        set_mode(2'd2);
        for (int i = 0; i < 3; i++) send(985, "R8 hold mode 2");
        set_mode(2'd1);
        send(985, "R8 resume");
        set_mode(2'd3);
        send(1010, "R8 hold mode 3");

        // R7: off forces zero, ignores events
        set_mode(2'd0);
        expect_corr("R7 off zero");
        @(negedge clk);
        send(985, "R7 off ignores");
        set_mode(2'd1);
        send(985, "R7 on after off");

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule